// File: doc/BRIEF.md
# Adaptive-Hysteresis Crank Edge Detector

This block turns the digitised waveform of a variable-reluctance crankshaft sensor into a clean digital tooth signal. An external converter delivers signed samples with a valid strobe. The block follows the signal's peak magnitude with a detector that charges at once and decays slowly. It derives a hysteresis band from that peak and switches its output only at a zero crossing, and only after the signal has passed the band on the opposite side.

The band is about 30 % of the tracked peak, computed as `(peak * 77) >> 8`. It never falls below a programmable static floor. With weak input the floor sets the band, and a signal whose magnitude never goes past the floor leaves the output at rest. The decay rate is set by a shift amount, so the same block can follow a slow cranking wheel and a fast-spinning wheel. Peak, band and tooth level are all registered outputs, so engine-management logic can read them directly.

Top module: `crank_edge_detect`

## Requirements
- R1: A clock edge with `rst` high makes the next outputs `tooth_o` = 0 and `peak_o` = 0, with `thresh_o` equal to `cfg_floor`, and clears any arming.
- R2: On an edge with `sample_valid` high where |sample| (an unsigned magnitude, with the most negative code giving 2^(W-1)) exceeds `peak_o`, `peak_o` becomes that magnitude after the edge.
- R3: On an edge with `sample_valid` high where |sample| is not above `peak_o`, `peak_o` becomes `peak_o - (peak_o >> cfg_decay_shift)`; a shift of 0 empties the peak.
- R4: On an edge with `sample_valid` low, `peak_o` and `tooth_o` keep their values.
- R5: After every edge out of reset, `thresh_o` equals max(`cfg_floor`, (`peak_o` * 77) >> 8), taking the `peak_o` value of that same edge and the `cfg_floor` present at the edge.
- R6: While `tooth_o` is 0, a valid sample strictly below −`thresh_o` arms the rise. The next valid sample that is ≥ 0 sets `tooth_o` to 1 after its edge. If that same sample is strictly above +`thresh_o`, it arms the fall at once.
- R7: The falling side mirrors R6. While `tooth_o` is 1, a valid sample strictly above +`thresh_o` arms the fall. The next valid sample that is < 0 clears `tooth_o`, and it arms the rise at once if it is strictly below −`thresh_o`.
- R8: A waveform whose magnitude stays at or below `cfg_floor` produces no `tooth_o` transition.
- R9: A noisy sinusoid whose noise is well inside the band produces exactly one rising edge of `tooth_o` per signal period, for rising and for falling amplitude once the peak has settled.
- R10: The most negative sample code is handled as magnitude 2^(W-1) in both the peak and the band (for W = 12: peak 2048, band 616).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_valid | input | 1 | Qualifies `sample_in` for this cycle |
| sample_in | input | SAMPLE_W | Signed two's-complement sensor sample |
| cfg_decay_shift | input | SHIFT_W | Right-shift amount setting the peak decay rate |
| cfg_floor | input | SAMPLE_W | Static hysteresis floor (unsigned) |
| tooth_o | output | 1 | Registered tooth level |
| peak_o | output | SAMPLE_W | Tracked peak magnitude (unsigned) |
| thresh_o | output | SAMPLE_W | Current hysteresis band (unsigned) |

## Verification
Each output is due one clock edge after the sample that drives it. The tooth decision compares a sample against the band registered at the previous edge. The new peak and band appear together after the same edge. The bench drives every sample half a period before the edge, advances its behavioural model at that edge, and compares all three outputs one time unit later, so every value is checked in the cycle it is due. Per-period edge counts for the sinusoid phases are taken from the observed `tooth_o` over windows that start half a period away from the zero crossings. Jitter in the exact crossing sample therefore cannot move a pulse into the wrong window.

// File: rtl/cedt_pkg.sv
package cedt_pkg;
  // Fixed-point factor for the dynamic band: 77/256 ~= 0.30
  localparam int unsigned BAND_NUM   = 77;
  localparam int unsigned BAND_SHIFT = 8;

  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } tooth_lvl_e;
endpackage

// File: rtl/cedt_peak_track.sv
module cedt_peak_track #(
  parameter int SAMPLE_W = 12,
  parameter int SHIFT_W  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       valid,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic [SHIFT_W-1:0]         decay_shift,
  output logic [SAMPLE_W-1:0]        peak_q,
  output logic [SAMPLE_W-1:0]        peak_d
);
  localparam int EXT_W = SAMPLE_W + 1;

  logic signed [EXT_W-1:0] s_ext;
  logic signed [EXT_W-1:0] s_neg;
  logic [SAMPLE_W-1:0]     mag;
  logic [SAMPLE_W-1:0]     decay_amt;
  logic                    charge;

  // Magnitude in SAMPLE_W unsigned bits; the most negative code maps to 2^(W-1)
  always_comb begin
    s_ext = {sample[SAMPLE_W-1], sample};
    s_neg = -s_ext;
    mag   = sample[SAMPLE_W-1] ? s_neg[SAMPLE_W-1:0] : s_ext[SAMPLE_W-1:0];
  end

  assign decay_amt = peak_q >> decay_shift;
  assign charge    = mag > peak_q;

  always_comb begin
    peak_d = peak_q;
    if (valid) begin
      if (charge) peak_d = mag;
      else        peak_d = peak_q - decay_amt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) peak_q <= '0;
    else     peak_q <= peak_d;
  end
endmodule

// File: rtl/cedt_band_calc.sv
module cedt_band_calc #(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] peak_d,
  input  logic [SAMPLE_W-1:0] floor_lvl,
  output logic [SAMPLE_W-1:0] thresh_q
);
  import cedt_pkg::*;

  localparam int NUM_W  = $clog2(BAND_NUM + 1);
  localparam int PROD_W = SAMPLE_W + NUM_W;

  logic [PROD_W-1:0]   prod;
  logic [PROD_W-1:0]   prod_sh;
  logic [SAMPLE_W-1:0] dyn_band;
  logic [SAMPLE_W-1:0] band_d;

  assign prod     = PROD_W'(peak_d) * PROD_W'(BAND_NUM);
  assign prod_sh  = prod >> BAND_SHIFT;
  assign dyn_band = prod_sh[SAMPLE_W-1:0];

  // Static floor wins whenever it is larger than the scaled peak
  assign band_d = (dyn_band > floor_lvl) ? dyn_band : floor_lvl;

  always_ff @(posedge clk) begin
    if (rst) thresh_q <= floor_lvl;
    else     thresh_q <= band_d;
  end
endmodule

// File: rtl/cedt_zero_cross.sv
module cedt_zero_cross #(
  parameter int SAMPLE_W = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       valid,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic [SAMPLE_W-1:0]        band,
  output logic                       tooth_q
);
  import cedt_pkg::*;

  localparam int EXT_W = SAMPLE_W + 1;

  tooth_lvl_e              lvl_q;
  logic                    armed_q;
  logic signed [EXT_W-1:0] s_ext;
  logic signed [EXT_W-1:0] b_pos;
  logic signed [EXT_W-1:0] b_neg;
  logic                    below_band;
  logic                    above_band;
  logic                    non_neg;

  always_comb begin
    s_ext      = {sample[SAMPLE_W-1], sample};
    b_pos      = $signed({1'b0, band});
    b_neg      = -b_pos;
    below_band = s_ext < b_neg;
    above_band = s_ext > b_pos;
    non_neg    = ~sample[SAMPLE_W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q   <= LVL_LOW;
      armed_q <= 1'b0;
    end else if (valid) begin
      unique case (lvl_q)
        LVL_LOW: begin
          if (armed_q && non_neg) begin
            lvl_q   <= LVL_HIGH;
            armed_q <= above_band;
          end else if (below_band) begin
            armed_q <= 1'b1;
          end
        end
        LVL_HIGH: begin
          if (armed_q && !non_neg) begin
            lvl_q   <= LVL_LOW;
            armed_q <= below_band;
          end else if (above_band) begin
            armed_q <= 1'b1;
          end
        end
        default: lvl_q <= LVL_LOW;
      endcase
    end
  end

  assign tooth_q = (lvl_q == LVL_HIGH);
endmodule

// File: rtl/crank_edge_detect.sv
module crank_edge_detect #(
  parameter int SAMPLE_W = 12,
  parameter int SHIFT_W  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sample_valid,
  input  logic signed [SAMPLE_W-1:0] sample_in,
  input  logic [SHIFT_W-1:0]         cfg_decay_shift,
  input  logic [SAMPLE_W-1:0]        cfg_floor,
  output logic                       tooth_o,
  output logic [SAMPLE_W-1:0]        peak_o,
  output logic [SAMPLE_W-1:0]        thresh_o
);
  logic [SAMPLE_W-1:0] peak_next;

  cedt_peak_track #(.SAMPLE_W(SAMPLE_W), .SHIFT_W(SHIFT_W)) u_peak (
    .clk         (clk),
    .rst         (rst),
    .valid       (sample_valid),
    .sample      (sample_in),
    .decay_shift (cfg_decay_shift),
    .peak_q      (peak_o),
    .peak_d      (peak_next)
  );

  cedt_band_calc #(.SAMPLE_W(SAMPLE_W)) u_band (
    .clk       (clk),
    .rst       (rst),
    .peak_d    (peak_next),
    .floor_lvl (cfg_floor),
    .thresh_q  (thresh_o)
  );

  // The crossing decision uses the band registered at the previous edge
  cedt_zero_cross #(.SAMPLE_W(SAMPLE_W)) u_cross (
    .clk     (clk),
    .rst     (rst),
    .valid   (sample_valid),
    .sample  (sample_in),
    .band    (thresh_o),
    .tooth_q (tooth_o)
  );
endmodule

// File: rtl/cedt_checker.sv
module cedt_checker #(
  parameter int SAMPLE_W = 12,
  parameter int SHIFT_W  = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       sample_valid,
  input logic signed [SAMPLE_W-1:0] sample_in,
  input logic [SHIFT_W-1:0]         cfg_decay_shift,
  input logic [SAMPLE_W-1:0]        cfg_floor,
  input logic                       tooth_o,
  input logic [SAMPLE_W-1:0]        peak_o,
  input logic [SAMPLE_W-1:0]        thresh_o
);
  logic [SAMPLE_W-1:0] chk_mag;
  logic                rst_d;

  assign chk_mag = sample_in[SAMPLE_W-1] ? (~sample_in + 1'b1) : sample_in;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d) begin
      assert_reset_clears_R1: assert (peak_o == '0 && !tooth_o);
    end
  end

  assert_charge_R2: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && chk_mag > peak_o) |=> (peak_o == $past(chk_mag)));

  assert_decay_R3: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && chk_mag <= peak_o) |=> (peak_o <= $past(peak_o)));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !sample_valid |=> ($stable(peak_o) && $stable(tooth_o)));

  assert_band_floor_R5: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (thresh_o >= $past(cfg_floor)));

  assert_rise_nonneg_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(tooth_o) |-> ($past(sample_valid) && !$past(sample_in[SAMPLE_W-1])));

  assert_fall_neg_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(tooth_o) |-> ($past(sample_valid) && $past(sample_in[SAMPLE_W-1])));
endmodule

bind crank_edge_detect cedt_checker #(.SAMPLE_W(SAMPLE_W), .SHIFT_W(SHIFT_W)) u_cedt_checker (
  .clk             (clk),
  .rst             (rst),
  .sample_valid    (sample_valid),
  .sample_in       (sample_in),
  .cfg_decay_shift (cfg_decay_shift),
  .cfg_floor       (cfg_floor),
  .tooth_o         (tooth_o),
  .peak_o          (peak_o),
  .thresh_o        (thresh_o)
);

// File: tb/crank_edge_detect_bench.sv
`timescale 1ns/1ps
module crank_edge_detect_bench;
  localparam int W  = 12;
  localparam int SW = 4;
  localparam int PERIOD = 40;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                sample_valid = 1'b0;
  logic signed [W-1:0] sample_in = '0;
  logic [SW-1:0]       cfg_decay_shift = 4'd5;
  logic [W-1:0]        cfg_floor = 12'd100;
  logic                tooth_o;
  logic [W-1:0]        peak_o;
  logic [W-1:0]        thresh_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int m_peak = 0, m_thr = 0, m_pul = 0, m_arm = 0;
  int cur_s = 0;
  int win_rises = 0;
  logic prev_tooth = 1'b0;
  string tooth_tag = "R1";

  always #2 clk = ~clk;

  crank_edge_detect #(.SAMPLE_W(W), .SHIFT_W(SW)) u_crank_edge_detect (
    .clk(clk), .rst(rst), .sample_valid(sample_valid), .sample_in(sample_in),
    .cfg_decay_shift(cfg_decay_shift), .cfg_floor(cfg_floor),
    .tooth_o(tooth_o), .peak_o(peak_o), .thresh_o(thresh_o)
  );

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: act %0d cycles exp fewer", cyc);
      report();
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act %0d exp %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Behavioural reference, advanced once per clock edge
  task automatic model_edge;
    int mag;
    if (rst) begin
      m_peak = 0; m_pul = 0; m_arm = 0; m_thr = int'(cfg_floor);
    end else begin
      if (sample_valid) begin
        mag = (cur_s < 0) ? -cur_s : cur_s;
        if (m_pul == 0) begin
          if (m_arm == 1 && cur_s >= 0) begin m_pul = 1; m_arm = (cur_s > m_thr) ? 1 : 0; end
          else if (cur_s < -m_thr) m_arm = 1;
        end else begin
          if (m_arm == 1 && cur_s < 0) begin m_pul = 0; m_arm = (cur_s < -m_thr) ? 1 : 0; end
          else if (cur_s > m_thr) m_arm = 1;
        end
        if (mag > m_peak) m_peak = mag;
        else m_peak = m_peak - (m_peak >> int'(cfg_decay_shift));
      end
      m_thr = (m_peak * 77) / 256;
      if (m_thr < int'(cfg_floor)) m_thr = int'(cfg_floor);
    end
  endtask

  task automatic step(input logic v, input int s);
    @(negedge clk);
    sample_valid = v;
    cur_s = s;
    sample_in = W'(s);
    @(posedge clk);
    #1;
    model_edge();
    check("R2 R3 R4 peak", int'(peak_o), m_peak);
    check("R5 band", int'(thresh_o), m_thr);
    check({tooth_tag, " tooth"}, int'(tooth_o), m_pul);
    if (tooth_o && !prev_tooth) win_rises++;
    prev_tooth = tooth_o;
  endtask

  task automatic run_sine(input int amp, input int noise, input int periods,
                          input int skip, input int exp_per_win, input string tag);
    int s;
    for (int c = 0; c < periods; c++) begin
      for (int i = 0; i < PERIOD; i++) begin
        if (i == PERIOD/2) begin
          if (c > skip) check(tag, win_rises, exp_per_win);
          win_rises = 0;
        end
        s = int'(real'(amp) * $sin(2.0 * 3.14159265358979 * real'(i) / real'(PERIOD)));
        s = s + int'($urandom_range(2*noise)) - noise;
        step(1'b1, s);
      end
    end
  endtask

  initial begin
    tooth_tag = "R1";
    rst = 1'b1;
    for (int k = 0; k < 3; k++) step(1'b1, 700);
    check("R1 reset tooth", int'(tooth_o), 0);
    check("R1 reset peak", int'(peak_o), 0);
    check("R1 reset band", int'(thresh_o), 100);
    rst = 1'b0;

    // R10: most negative code
    tooth_tag = "R10";
    cfg_decay_shift = 4'd15;
    step(1'b1, -2048);
    check("R10 peak", int'(peak_o), 2048);
    check("R10 band", int'(thresh_o), 616);

    // R6 and R7 directed arming, floor-dominated band
    rst = 1'b1; step(1'b0, 0); rst = 1'b0;
    tooth_tag = "R6";
    step(1'b1, -50);  step(1'b1, 10);
    check("R6 no arm inside band", int'(tooth_o), 0);
    step(1'b1, -150); step(1'b1, -20);
    check("R6 armed still low", int'(tooth_o), 0);
    step(1'b1, 0);
    check("R6 rise at zero", int'(tooth_o), 1);
    tooth_tag = "R7";
    step(1'b1, 50); step(1'b1, -5);
    check("R7 no fall unarmed", int'(tooth_o), 1);
    step(1'b1, 200); step(1'b1, 30);
    check("R7 armed still high", int'(tooth_o), 1);
    step(1'b1, -1);
    check("R7 fall below zero", int'(tooth_o), 0);

    // R4: idle cycles hold the peak; R3 with shift 0 empties it
    tooth_tag = "R4";
    for (int k = 0; k < 5; k++) step(1'b0, 1500);
    check("R4 peak held", int'(peak_o), 200);
    tooth_tag = "R3";
    cfg_decay_shift = 4'd0;
    step(1'b1, 3);
    check("R3 shift zero", int'(peak_o), 0);

    // R9: sinusoids of falling and rising amplitude, R8 below the floor
    cfg_decay_shift = 4'd5;
    tooth_tag = "R9";
    run_sine(1500, 40, 10, 2, 1, "R9 large");
    run_sine(400, 20, 12, 6, 1, "R9 falling");
    run_sine(1200, 30, 8, 2, 1, "R9 rising");
    tooth_tag = "R8";
    run_sine(90, 5, 20, 12, 0, "R8 below floor");

    // Mixed gaps and random configuration against the model
    tooth_tag = "R5";
    for (int k = 0; k < 2000; k++) begin
      if (k % 250 == 0) begin
        cfg_decay_shift = SW'($urandom_range(7));
        cfg_floor = W'($urandom_range(300));
      end
      step(($urandom_range(3) != 0), int'($urandom_range(4095)) - 2048);
    end
    report();
  end
endmodule